// File: doc/BRIEF.md
# Event-Driven Multi-Output Match Timer

This block is a free-running 32-bit up-counter with sixteen compare registers, sixteen events and sixteen outputs. An event fires when the counter equals the compare register that the event selects. Each output has its own mask of events that drive it high and its own mask of events that drive it low. A two-bit rule per output decides the result when both masks hit in the same cycle. A mask of events can return the counter to zero, which makes one event the period of a pulse train. Other events then place the edges inside that period.

Software programs the timer through a small synchronous register port. Each compare register has a shadow value. The shadow values are copied into the live compare registers at the period boundary, so duty changes take effect cleanly. A halt bit freezes the counter. An 8-bit prescaler slows the count by a factor of prescale+1.

Top module: `match_event_timer`

## Requirements
- R1: After a synchronous reset every output is 0 and the counter is 0. Every register reads 0, except the control word at 0x004, which reads 0x4 (halt set).
- R2: Byte addresses are as follows: config 0x000, control 0x004, limit 0x008, resolution 0x00C, compare n 0x100+4n, shadow n 0x140+4n, event control n 0x180+4n, high mask n 0x1C0+4n, low mask n 0x200+4n. The two low address bits are ignored. A read with rd_en returns data on rdata one clock later and returns 0 when rd_en is low. Unmapped addresses and unimplemented bits read 0.
- R3: When halt (control bit 2) is 0, the counter advances once every prescale+1 clocks, where prescale is control bits 12:5. That clock is the tick. While halt is 1, the counter and prescaler hold and no event fires.
- R4: Event n fires on a tick when its control bits 13:12 equal 1 and the counter equals the compare register chosen by its bits 3:0. Any other value in bits 13:12 disables the event.
- R5: If a firing event is set in the limit mask (bits 15:0), the counter becomes 0 on that tick instead of incrementing. All events are evaluated on the value the counter had before the reset, so several can fire together.
- R6: On a limit reset every compare register takes its shadow value, unless config bit 7 is 1. A write to a compare register in that same cycle takes priority over the copy.
- R7: Output o goes to 1 at the clock edge ending a tick on which an event in its high mask fires and no event in its low mask fires. It goes to 0 in the mirror case, and it holds when neither mask hits.
- R8: When both masks of output o hit on one tick, resolution bits 2o+1:2o select the result: 0 hold, 1 high, 2 low, 3 invert.
- R9: With the limit event's compare at P, prescale 0, high-on-limit and low-on-duty at D<P, the output is high D+1 of every P+1 clocks. With D=P and resolution 1, the output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one clock after rd_en |
| tmr_out | output | 16 | Registered timer outputs |

## Verification
A fault in the counter, prescaler or limit logic shifts the edges of every output that uses the period event. The shift appears on tmr_out within one programmed period. A wrong compare or shadow value moves only the edges of the outputs that depend on it, and it shows up after the next limit reset. A corrupted register shows on rdata one clock after it is read. The bench compares both tmr_out and rdata against an independent model on every clock, so a divergence is caught in the cycle it first reaches a port.

// File: rtl/mtm_pkg.sv
`timescale 1ns/1ps
package mtm_pkg;
  typedef enum logic [1:0] {
    RES_HOLD = 2'd0,
    RES_SET  = 2'd1,
    RES_CLR  = 2'd2,
    RES_TOG  = 2'd3
  } res_code_e;

  // address banks: addr[ADDR_W-1:6], slot: addr[5:2]
  localparam int BANK_SCALAR = 0;
  localparam int BANK_MATCH  = 4;
  localparam int BANK_RELOAD = 5;
  localparam int BANK_EVCTL  = 6;
  localparam int BANK_SETM   = 7;
  localparam int BANK_CLRM   = 8;

  localparam int SLOT_CFG   = 0;
  localparam int SLOT_CTRL  = 1;
  localparam int SLOT_LIMIT = 2;
  localparam int SLOT_RES   = 3;

  localparam int NORELOAD_BIT = 7;
  localparam int HALT_BIT     = 2;
  localparam int PRE_LSB      = 5;
  localparam int COMB_LSB     = 12;
  localparam logic [1:0] COMB_MATCH_ONLY = 2'd1;
endpackage

// File: rtl/mtm_regs.sv
`timescale 1ns/1ps
module mtm_regs
  import mtm_pkg::*;
#(
  parameter int NUM_EV  = 16,
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 8,
  parameter int SEL_W   = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic                 wrap,
  output logic                 halt,
  output logic [PRE_W-1:0]     prescale,
  output logic [NUM_EV-1:0]    limit_mask,
  output logic [2*NUM_OUT-1:0] res_bits,
  output logic [CNT_W-1:0]     match_val [NUM_EV],
  output logic [SEL_W-1:0]     ev_sel [NUM_EV],
  output logic [NUM_EV-1:0]    ev_on,
  output logic [NUM_EV-1:0]    set_mask [NUM_OUT],
  output logic [NUM_EV-1:0]    clr_mask [NUM_OUT]
);
  localparam int SLOT_W = 4;
  localparam int BANK_W = ADDR_W - SLOT_W - 2;

  logic [BANK_W-1:0] bank;
  logic [SLOT_W-1:0] slot;
  logic wr_scalar, wr_match, wr_reload, wr_evctl, wr_setm, wr_clrm;
  logic norel_q, reload_now;
  logic [CNT_W-1:0] reload_q [NUM_EV];
  logic [1:0]       comb_q   [NUM_EV];
  logic [DATA_W-1:0] rd_val;
  logic unused_bits;

  assign bank        = addr[ADDR_W-1:SLOT_W+2];
  assign slot        = addr[SLOT_W+1:2];
  assign unused_bits = ^{addr[1:0], wdata};

  assign wr_scalar = wr_en && (bank == BANK_W'(BANK_SCALAR));
  assign wr_match  = wr_en && (bank == BANK_W'(BANK_MATCH));
  assign wr_reload = wr_en && (bank == BANK_W'(BANK_RELOAD));
  assign wr_evctl  = wr_en && (bank == BANK_W'(BANK_EVCTL));
  assign wr_setm   = wr_en && (bank == BANK_W'(BANK_SETM));
  assign wr_clrm   = wr_en && (bank == BANK_W'(BANK_CLRM));
  assign reload_now = wrap && !norel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      norel_q    <= 1'b0;
      halt       <= 1'b1;
      prescale   <= '0;
      limit_mask <= '0;
      res_bits   <= '0;
    end else if (wr_scalar) begin
      case (slot)
        SLOT_W'(SLOT_CFG):   norel_q <= wdata[NORELOAD_BIT];
        SLOT_W'(SLOT_CTRL): begin
          halt     <= wdata[HALT_BIT];
          prescale <= wdata[PRE_LSB +: PRE_W];
        end
        SLOT_W'(SLOT_LIMIT): limit_mask <= wdata[NUM_EV-1:0];
        SLOT_W'(SLOT_RES):   res_bits   <= wdata[2*NUM_OUT-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int n = 0; n < NUM_EV; n++) begin
      if (rst) begin
        match_val[n] <= '0;
        reload_q[n]  <= '0;
        ev_sel[n]    <= '0;
        comb_q[n]    <= '0;
      end else begin
        if (wr_match && slot == SLOT_W'(n))
          match_val[n] <= wdata[CNT_W-1:0];
        else if (reload_now)
          match_val[n] <= reload_q[n];
        if (wr_reload && slot == SLOT_W'(n))
          reload_q[n] <= wdata[CNT_W-1:0];
        if (wr_evctl && slot == SLOT_W'(n)) begin
          ev_sel[n] <= wdata[SEL_W-1:0];
          comb_q[n] <= wdata[COMB_LSB +: 2];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < NUM_OUT; o++) begin
      if (rst) begin
        set_mask[o] <= '0;
        clr_mask[o] <= '0;
      end else begin
        if (wr_setm && slot == SLOT_W'(o)) set_mask[o] <= wdata[NUM_EV-1:0];
        if (wr_clrm && slot == SLOT_W'(o)) clr_mask[o] <= wdata[NUM_EV-1:0];
      end
    end
  end

  for (genvar n = 0; n < NUM_EV; n++) begin : g_on
    assign ev_on[n] = (comb_q[n] == COMB_MATCH_ONLY);
  end

  always_comb begin
    rd_val = '0;
    case (bank)
      BANK_W'(BANK_SCALAR): begin
        case (slot)
          SLOT_W'(SLOT_CFG):   rd_val[NORELOAD_BIT] = norel_q;
          SLOT_W'(SLOT_CTRL): begin
            rd_val[HALT_BIT]          = halt;
            rd_val[PRE_LSB +: PRE_W]  = prescale;
          end
          SLOT_W'(SLOT_LIMIT): rd_val[NUM_EV-1:0]    = limit_mask;
          SLOT_W'(SLOT_RES):   rd_val[2*NUM_OUT-1:0] = res_bits;
          default: ;
        endcase
      end
      BANK_W'(BANK_MATCH):
        if (int'(slot) < NUM_EV) rd_val[CNT_W-1:0] = match_val[slot];
      BANK_W'(BANK_RELOAD):
        if (int'(slot) < NUM_EV) rd_val[CNT_W-1:0] = reload_q[slot];
      BANK_W'(BANK_EVCTL):
        if (int'(slot) < NUM_EV) begin
          rd_val[SEL_W-1:0]     = ev_sel[slot];
          rd_val[COMB_LSB +: 2] = comb_q[slot];
        end
      BANK_W'(BANK_SETM):
        if (int'(slot) < NUM_OUT) rd_val[NUM_EV-1:0] = set_mask[slot];
      BANK_W'(BANK_CLRM):
        if (int'(slot) < NUM_OUT) rd_val[NUM_EV-1:0] = clr_mask[slot];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_val : '0;
  end

  for (genvar n = 0; n < NUM_EV; n++) begin : g_chk
    AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (rst) (reload_now && !(wr_match && slot == SLOT_W'(n))) |=> (match_val[n] == $past(reload_q[n]))); // R6
    AST_NORELOAD_HOLD: assert property (@(posedge clk) disable iff (rst) (wrap && norel_q && !(wr_match && slot == SLOT_W'(n))) |=> $stable(match_val[n])); // R6
  end
endmodule

// File: rtl/mtm_counter.sv
`timescale 1ns/1ps
module mtm_counter #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic [PRE_W-1:0] prescale,
  input  logic             limit_hit,
  output logic [CNT_W-1:0] count,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  assign tick = !halt && (pre_q >= prescale);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      pre_q <= '0;
    end else if (!halt) begin
      if (tick) begin
        pre_q <= '0;
        count <= limit_hit ? '0 : count + CNT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst) halt |=> $stable(count)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> (count == $past(count))); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst) (tick && !limit_hit) |=> (count == $past(count) + CNT_W'(1))); // R3
  AST_LIMIT_WRAP: assert property (@(posedge clk) disable iff (rst) (tick && limit_hit) |=> (count == '0)); // R5
endmodule

// File: rtl/mtm_events.sv
`timescale 1ns/1ps
module mtm_events #(
  parameter int NUM_EV = 16,
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 4
) (
  input  logic [CNT_W-1:0]  count,
  input  logic              tick,
  input  logic [CNT_W-1:0]  match_val [NUM_EV],
  input  logic [SEL_W-1:0]  ev_sel [NUM_EV],
  input  logic [NUM_EV-1:0] ev_on,
  input  logic [NUM_EV-1:0] limit_mask,
  output logic [NUM_EV-1:0] ev_fire,
  output logic              limit_hit
);
  for (genvar e = 0; e < NUM_EV; e++) begin : g_cmp
    assign ev_fire[e] = tick && ev_on[e] && (count == match_val[ev_sel[e]]);
  end

  assign limit_hit = |(ev_fire & limit_mask);
endmodule

// File: rtl/mtm_outputs.sv
`timescale 1ns/1ps
module mtm_outputs
  import mtm_pkg::*;
#(
  parameter int NUM_EV  = 16,
  parameter int NUM_OUT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EV-1:0]    ev_fire,
  input  logic [NUM_EV-1:0]    set_mask [NUM_OUT],
  input  logic [NUM_EV-1:0]    clr_mask [NUM_OUT],
  input  logic [2*NUM_OUT-1:0] res_bits,
  output logic [NUM_OUT-1:0]   out_q
);
  logic [NUM_OUT-1:0] set_hit, clr_hit;

  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      set_hit[o] = |(set_mask[o] & ev_fire);
      clr_hit[o] = |(clr_mask[o] & ev_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else begin
      for (int o = 0; o < NUM_OUT; o++) begin
        if (set_hit[o] && clr_hit[o]) begin
          case (res_code_e'(res_bits[2*o +: 2]))
            RES_SET: out_q[o] <= 1'b1;
            RES_CLR: out_q[o] <= 1'b0;
            RES_TOG: out_q[o] <= ~out_q[o];
            default: ;
          endcase
        end else if (set_hit[o]) begin
          out_q[o] <= 1'b1;
        end else if (clr_hit[o]) begin
          out_q[o] <= 1'b0;
        end
      end
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    AST_SET_ALONE: assert property (@(posedge clk) disable iff (rst) (set_hit[o] && !clr_hit[o]) |=> out_q[o]); // R7
    AST_CLR_ALONE: assert property (@(posedge clk) disable iff (rst) (clr_hit[o] && !set_hit[o]) |=> !out_q[o]); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!set_hit[o] && !clr_hit[o]) |=> $stable(out_q[o])); // R7
    AST_CONFLICT_TOGGLE: assert property (@(posedge clk) disable iff (rst) (set_hit[o] && clr_hit[o] && res_bits[2*o +: 2] == 2'd3) |=> (out_q[o] != $past(out_q[o]))); // R8
  end
endmodule

// File: rtl/match_event_timer.sv
`timescale 1ns/1ps
module match_event_timer #(
  parameter int NUM_EV  = 16,
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_OUT-1:0] tmr_out
);
  localparam int SEL_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;

  logic                 halt, tick, limit_hit, wrap;
  logic [PRE_W-1:0]     prescale;
  logic [NUM_EV-1:0]    limit_mask, ev_on, ev_fire;
  logic [2*NUM_OUT-1:0] res_bits;
  logic [CNT_W-1:0]     match_val [NUM_EV];
  logic [SEL_W-1:0]     ev_sel [NUM_EV];
  logic [NUM_EV-1:0]    set_mask [NUM_OUT];
  logic [NUM_EV-1:0]    clr_mask [NUM_OUT];
  logic [CNT_W-1:0]     count;

  assign wrap = tick && limit_hit;

  mtm_regs #(
    .NUM_EV(NUM_EV), .NUM_OUT(NUM_OUT), .CNT_W(CNT_W), .PRE_W(PRE_W),
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wrap(wrap), .halt(halt),
    .prescale(prescale), .limit_mask(limit_mask), .res_bits(res_bits),
    .match_val(match_val), .ev_sel(ev_sel), .ev_on(ev_on),
    .set_mask(set_mask), .clr_mask(clr_mask)
  );

  mtm_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_counter (
    .clk(clk), .rst(rst), .halt(halt), .prescale(prescale),
    .limit_hit(limit_hit), .count(count), .tick(tick)
  );

  mtm_events #(.NUM_EV(NUM_EV), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_events (
    .count(count), .tick(tick), .match_val(match_val), .ev_sel(ev_sel),
    .ev_on(ev_on), .limit_mask(limit_mask), .ev_fire(ev_fire),
    .limit_hit(limit_hit)
  );

  mtm_outputs #(.NUM_EV(NUM_EV), .NUM_OUT(NUM_OUT)) u_outputs (
    .clk(clk), .rst(rst), .ev_fire(ev_fire), .set_mask(set_mask),
    .clr_mask(clr_mask), .res_bits(res_bits), .out_q(tmr_out)
  );
endmodule

// File: tb/match_event_timer_test.sv
`timescale 1ns/1ps
module match_event_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] tmr_out;

  always #5 clk = ~clk;

  match_event_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out)
  );

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1";

  // behavioural reference model
  bit [31:0] m_cnt, m_res, m_rd;
  bit [7:0]  m_pre, m_presc;
  bit        m_halt, m_norel;
  bit [15:0] m_lim, m_out;
  bit [31:0] m_match [16];
  bit [31:0] m_reload[16];
  bit [3:0]  m_sel   [16];
  bit [1:0]  m_comb  [16];
  bit [15:0] m_set   [16];
  bit [15:0] m_clr   [16];

  task automatic model_reset();
    m_cnt = 0; m_res = 0; m_rd = 0; m_pre = 0; m_presc = 0;
    m_halt = 1; m_norel = 0; m_lim = 0; m_out = 0;
    for (int i = 0; i < 16; i++) begin
      m_match[i] = 0; m_reload[i] = 0; m_sel[i] = 0; m_comb[i] = 0;
      m_set[i] = 0; m_clr[i] = 0;
    end
  endtask

  function automatic bit [31:0] model_read(bit [11:0] a);
    int b = int'(a[11:6]);
    int s = int'(a[5:2]);
    case (b)
      0: case (s)
           0: return {24'd0, m_norel, 7'd0};
           1: return (32'(m_halt) << 2) | (32'(m_presc) << 5);
           2: return {16'd0, m_lim};
           3: return m_res;
           default: return 0;
         endcase
      4: return m_match[s];
      5: return m_reload[s];
      6: return (32'(m_comb[s]) << 12) | 32'(m_sel[s]);
      7: return {16'd0, m_set[s]};
      8: return {16'd0, m_clr[s]};
      default: return 0;
    endcase
  endfunction

  task automatic model_step(bit we, bit re, bit [11:0] a, bit [31:0] d);
    bit [31:0] rd_n = re ? model_read(a) : 32'd0;
    bit        tk = !m_halt && (m_pre >= m_presc);
    bit [15:0] ev = 0;
    bit        lh;
    int        b = int'(a[11:6]);
    int        s = int'(a[5:2]);
    for (int e = 0; e < 16; e++)
      if (tk && m_comb[e] == 2'd1 && m_cnt == m_match[m_sel[e]]) ev[e] = 1;
    lh = |(ev & m_lim);
    for (int o = 0; o < 16; o++) begin
      bit sh = |(m_set[o] & ev);
      bit ch = |(m_clr[o] & ev);
      if (sh && ch) begin
        case (m_res[2*o +: 2])
          2'd1: m_out[o] = 1;
          2'd2: m_out[o] = 0;
          2'd3: m_out[o] = ~m_out[o];
          default: ;
        endcase
      end else if (sh) m_out[o] = 1;
      else if (ch) m_out[o] = 0;
    end
    if (!m_halt) begin
      if (tk) begin
        m_pre = 0;
        if (lh) begin
          m_cnt = 0;
          if (!m_norel) for (int n = 0; n < 16; n++) m_match[n] = m_reload[n];
        end else m_cnt = m_cnt + 1;
      end else m_pre = m_pre + 1;
    end
    if (we) begin
      case (b)
        0: case (s)
             0: m_norel = d[7];
             1: begin m_halt = d[2]; m_presc = d[12:5]; end
             2: m_lim = d[15:0];
             3: m_res = d;
             default: ;
           endcase
        4: m_match[s] = d;
        5: m_reload[s] = d;
        6: begin m_sel[s] = d[3:0]; m_comb[s] = d[13:12]; end
        7: m_set[s] = d[15:0];
        8: m_clr[s] = d[15:0];
        default: ;
      endcase
    end
    m_rd = rd_n;
  endtask

  task automatic chk(bit ok, string req, string what, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(tmr_out === m_out, phase, "tmr_out", 32'(tmr_out), 32'(m_out));
    chk(rdata === m_rd, phase, "rdata", rdata, m_rd);
  endtask

  task automatic step(bit we, bit re, bit [11:0] a, bit [31:0] d);
    @(negedge clk);
    compare();
    wr_en = we; rd_en = re; addr = a; wdata = d;
    model_step(we, re, a, d);
  endtask

  task automatic wr(bit [11:0] a, bit [31:0] d);
    step(1'b1, 1'b0, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic rd(bit [11:0] a, bit [31:0] exp, string req);
    step(1'b0, 1'b1, a, 32'h0);
    @(negedge clk);
    compare();
    chk(rdata === exp, req, "register read", rdata, exp);
    wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    model_step(1'b0, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic count_high(int bitn, int n, int exp, string req);
    int h = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b0, 12'h0, 32'h0);
      h += int'(tmr_out[bitn]);
    end
    chk(h == exp, req, "high clocks in window", 32'(h), 32'(exp));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(10ns * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired in phase %s actual=running expected=done", phase);
    summary();
    $finish;
  end

  initial begin
    bit [15:0] held;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    chk(tmr_out === 16'h0, "R1", "tmr_out in reset", 32'(tmr_out), 0);
    chk(rdata === 32'h0, "R1", "rdata in reset", rdata, 0);
    rst = 0;
    model_step(1'b0, 1'b0, 12'h0, 32'h0);

    // R1: reset register values
    rd(12'h004, 32'h4, "R1");
    rd(12'h000, 32'h0, "R1");
    rd(12'h100, 32'h0, "R1");
    rd(12'h1C0, 32'h0, "R1");

    // R2: read-back, unimplemented bits, unmapped space
    phase = "R2";
    wr(12'h008, 32'hFFFF_A5A5);
    rd(12'h008, 32'h0000_A5A5, "R2");
    wr(12'h19C, 32'hFFFF_FFFF);
    rd(12'h19C, 32'h0000_300F, "R2");
    rd(12'h19F, 32'h0000_300F, "R2");
    rd(12'h3F0, 32'h0, "R2");
    rd(12'h240, 32'h0, "R2");
    wr(12'h19C, 32'h0);
    wr(12'h008, 32'h0);

    // pulse setup: period 9, duty 3, extra outputs
    phase = "R5 R7 R9";
    wr(12'h100, 9);  wr(12'h140, 9);
    wr(12'h104, 3);  wr(12'h144, 3);
    wr(12'h108, 6);  wr(12'h148, 6);
    wr(12'h180, 32'h1000);
    wr(12'h184, 32'h1001);
    wr(12'h188, 32'h1002);
    wr(12'h190, 32'h1001);       // event 4 selects compare 1
    wr(12'h008, 32'h1);          // limit on event 0
    wr(12'h1C0, 32'h1);  wr(12'h200, 32'h2);    // out0
    wr(12'h1CC, 32'h4);  wr(12'h20C, 32'h1);    // out3
    wr(12'h1D4, 32'h10); wr(12'h214, 32'h1);    // out5
    wr(12'h00C, 32'h1);
    wr(12'h004, 32'h0);
    idle(30);
    count_high(0, 10, 4, "R9");
    count_high(3, 10, 3, "R7");
    count_high(5, 10, 6, "R4");
    rd(12'h104, 3, "R6");

    // duty equals period: conflict every wrap
    phase = "R8 R9";
    wr(12'h104, 9); wr(12'h144, 9);
    idle(20);
    count_high(0, 10, 10, "R9");
    phase = "R8";
    wr(12'h00C, 32'h2);
    idle(20);
    count_high(0, 10, 0, "R8");
    wr(12'h00C, 32'h3);
    idle(25);
    count_high(0, 20, 10, "R8");
    wr(12'h00C, 32'h0);
    idle(25);
    wr(12'h104, 3); wr(12'h144, 3);
    wr(12'h00C, 32'h1);
    idle(20);

    // combine field other than 1 disables event 1
    phase = "R4";
    wr(12'h184, 32'h2001);
    idle(25);
    count_high(0, 10, 10, "R4");
    wr(12'h184, 32'h1001);
    idle(20);

    // shadow copy blocked, then allowed
    phase = "R6";
    wr(12'h000, 32'h80);
    wr(12'h144, 5);
    idle(25);
    rd(12'h104, 3, "R6");
    wr(12'h000, 32'h0);
    idle(25);
    rd(12'h104, 5, "R6");
    idle(20);
    count_high(0, 10, 6, "R6");

    // prescaler and halt
    phase = "R3";
    wr(12'h104, 3); wr(12'h144, 3);
    wr(12'h004, 32'h40);
    idle(60);
    count_high(0, 30, 12, "R3");
    wr(12'h004, 32'h44);
    idle(5);
    held = tmr_out;
    idle(20);
    chk(tmr_out === held, "R3", "outputs frozen by halt", 32'(tmr_out), 32'(held));
    rd(12'h004, 32'h44, "R3");
    wr(12'h004, 32'h0);
    idle(40);
    count_high(0, 10, 4, "R3");

    idle(2);
    summary();
    $finish;
  end
endmodule